// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address by reading page table entries from memory. The directory base input gives the physical page that holds the top-level directory. Virtual address bits 31..22 select one of 1024 directory entries, and bits 21..12 select one of 1024 entries in the second-level table. Bits 11..0 are the byte offset and pass straight through to the physical address. Each entry is a 32-bit word. Entry bits 31..12 give a physical frame, and the low bits carry attributes.

A requester hands in one address at a time, together with two flags: whether the access is a write and whether it comes from user mode. The walker issues word reads on a request/response memory port. When large pages are enabled, a directory entry with its page-size bit set ends the walk early with a 4 MB mapping. Each accepted request ends in exactly one result: either a translation with the leaf entry's global and cache-control bits, which a translation cache can store, or a fault with a three-bit code.

Top module: `va_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `memReqValid`, `doneValid` and `faultValid` are all 0.
- R2: The first read of a walk uses address {baseAddr[31:12], va[31:22], 2'b00}.
- R3: For a small-page walk, the second read uses address {pde[31:12], va[21:12], 2'b00}, and the translation is {pte[31:12], va[11:0]}. `doneLarge` is 0 for this walk.
- R4: When `largeEn` is 1 and a present directory entry has bit 7 set, the walk makes no second read. It ends with the translation {pde[31:22], va[21:0]} and `doneLarge` = 1.
- R5: When `largeEn` is 0, directory bit 7 has no effect: the walk goes on to the second-level read.
- R6: If the directory or table entry read has bit 0 (present) clear, the walk ends in a fault. The fault code is {user, write, 1'b0}: code bit 2 is the user flag, code bit 1 is the write flag, and code bit 0 is 0.
- R7: A write access faults with code bit 0 = 1 when bit 1 (writable) is clear in the directory entry, in the table entry, or in the large-page entry.
- R8: A user access faults with code bit 0 = 1 when bit 2 (user allowed) is clear at any level used. Supervisor accesses ignore bit 2, and reads ignore bit 1.
- R9: `memReqValid` and `memReqAddr` stay steady until `memRspValid` arrives, for any response delay.
- R10: A request is taken only while `reqReady` is 1. Requests that arrive during a walk are ignored. Each accepted request produces exactly one single-cycle pulse, on either `doneValid` or `faultValid`, after which `reqReady` returns to 1.
- R11: `doneAttr` = {bit 8 global, bit 4 cache disable, bit 3 write-through} of the leaf entry. Entry bits 11..9 do not affect any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseAddr | input | 32 | Physical address of the directory page; bits 31..12 are used |
| largeEn | input | 1 | Enables 4 MB pages |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker is idle and can take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | The access is a write |
| reqUser | input | 1 | The access is from user mode |
| memReqValid | output | 1 | Memory word read request |
| memReqAddr | output | 32 | Read address |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | Read data |
| doneValid | output | 1 | Translation result pulse |
| donePaddr | output | 32 | Physical address |
| doneAttr | output | 3 | {global, cache disable, write-through} |
| doneLarge | output | 1 | The result came from a 4 MB page |
| faultValid | output | 1 | Fault result pulse |
| faultCode | output | 3 | {user, write, protection violation} |

## Verification
The assertions assume that memory returns exactly one response per read and raises `memRspValid` only while `memReqValid` is high. They also assume that `baseAddr` and `largeEn` stay steady from acceptance until the result. The bench memory model answers only pending reads, after a delay that changes from case to case. It holds the base and the large-page enable constant across each walk. It also drives extra requests during a walk only to show that they are ignored.

// File: rtl/va_walker_pkg.sv
package va_walker_pkg;

  // Bit positions of an entry; decoded by the walker itself.
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_WTHRU   = 3;
  localparam int BIT_NOCACHE = 4;
  localparam int BIT_LARGE   = 7;
  localparam int BIT_GLOBAL  = 8;

  typedef enum logic [2:0] {
    stIdle,
    stReadDir,
    stReadTbl,
    stDone,
    stFault
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic latchDir;
    logic latchLeaf;
    logic latchFault;
    logic selTable;
  } walkCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic present;
    logic largeLeaf;
    logic permOk;
  } walkSts_t;

endpackage

// File: rtl/va_walker_data.sv
module va_walker_data
  import va_walker_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCtl_t            ctl,
  input  logic [2*IDX_W+OFF_W-1:0] baseAddr,
  input  logic                largeEn,
  input  logic [2*IDX_W+OFF_W-1:0] reqVaddr,
  input  logic                reqWrite,
  input  logic                reqUser,
  input  logic [2*IDX_W+OFF_W-1:0] memRspData,
  output logic [2*IDX_W+OFF_W-1:0] memReqAddr,
  output walkSts_t            sts,
  output logic [2*IDX_W+OFF_W-1:0] donePaddr,
  output logic [2:0]          doneAttr,
  output logic                doneLarge,
  output logic [2:0]          faultCode
);
  localparam int ADDR_W  = 2 * IDX_W + OFF_W;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int LOFF_W  = IDX_W + OFF_W;
  localparam int ENT_LSB = OFF_W - IDX_W;  // log2 of entry size in bytes

  logic [ADDR_W-1:0]  vaQ;
  logic               writeQ;
  logic               userQ;
  logic [FRAME_W-1:0] dirFrameQ;
  logic               dirWriteQ;
  logic               dirUserQ;
  logic [ADDR_W-1:0]  paddrQ;
  logic [2:0]         attrQ;
  logic               largeQ;
  logic [2:0]         codeQ;

  logic [IDX_W-1:0]   dirIdx;
  logic [IDX_W-1:0]   tblIdx;
  logic               effWrite;
  logic               effUser;
  logic [ADDR_W-1:0]  leafPaddr;
  logic               unusedBits;

  assign dirIdx = vaQ[ADDR_W-1 -: IDX_W];
  assign tblIdx = vaQ[OFF_W +: IDX_W];

  always_comb begin
    if (ctl.selTable)
      memReqAddr = {dirFrameQ, tblIdx, {ENT_LSB{1'b0}}};
    else
      memReqAddr = {baseAddr[ADDR_W-1:OFF_W], dirIdx, {ENT_LSB{1'b0}}};
  end

  // Permissions combine both levels on a small page
  always_comb begin
    effWrite = memRspData[BIT_WRITE];
    effUser  = memRspData[BIT_USER];
    if (ctl.selTable) begin
      effWrite = effWrite & dirWriteQ;
      effUser  = effUser & dirUserQ;
    end
  end

  assign sts.present   = memRspData[BIT_PRESENT];
  assign sts.largeLeaf = !ctl.selTable && largeEn && memRspData[BIT_LARGE];
  assign sts.permOk    = !(writeQ && !effWrite) && !(userQ && !effUser);

  always_comb begin
    if (ctl.selTable)
      leafPaddr = {memRspData[ADDR_W-1:OFF_W], vaQ[OFF_W-1:0]};
    else
      leafPaddr = {memRspData[ADDR_W-1 -: IDX_W], vaQ[LOFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      writeQ    <= 1'b0;
      userQ     <= 1'b0;
      dirFrameQ <= '0;
      dirWriteQ <= 1'b0;
      dirUserQ  <= 1'b0;
      paddrQ    <= '0;
      attrQ     <= '0;
      largeQ    <= 1'b0;
      codeQ     <= '0;
    end else begin
      if (ctl.latchReq) begin
        vaQ    <= reqVaddr;
        writeQ <= reqWrite;
        userQ  <= reqUser;
      end
      if (ctl.latchDir) begin
        dirFrameQ <= memRspData[ADDR_W-1:OFF_W];
        dirWriteQ <= memRspData[BIT_WRITE];
        dirUserQ  <= memRspData[BIT_USER];
      end
      if (ctl.latchLeaf) begin
        paddrQ <= leafPaddr;
        attrQ  <= {memRspData[BIT_GLOBAL], memRspData[BIT_NOCACHE], memRspData[BIT_WTHRU]};
        largeQ <= !ctl.selTable;
      end
      if (ctl.latchFault)
        codeQ <= {userQ, writeQ, memRspData[BIT_PRESENT]};
    end
  end

  assign donePaddr = paddrQ;
  assign doneAttr  = attrQ;
  assign doneLarge = largeQ;
  assign faultCode = codeQ;

  assign unusedBits = ^{baseAddr[OFF_W-1:0], memRspData[OFF_W-1:BIT_GLOBAL+1],
                        memRspData[BIT_LARGE-1:BIT_NOCACHE+1]};

  // A directory-level leaf only on a large page
  assert_large_leaf_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchLeaf && !ctl.selTable |-> largeEn && memRspData[BIT_LARGE]);

  // A leaf entry is never taken from a non-present entry
  assert_leaf_present_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchLeaf |-> memRspData[BIT_PRESENT]);

  // A write completes only through a writable leaf
  assert_leaf_writable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchLeaf && writeQ |-> memRspData[BIT_WRITE]);

  // A user access completes only through a user leaf
  assert_leaf_user_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchLeaf && userQ |-> memRspData[BIT_USER]);

endmodule

// File: rtl/va_walker_ctrl.sv
module va_walker_ctrl
  import va_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     reqReady,
  output logic     memReqValid,
  output logic     doneValid,
  output logic     faultValid
);
  walkState_t stateQ;
  walkState_t stateD;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      stIdle: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateD       = stReadDir;
        end
      end
      stReadDir: begin
        if (memRspValid) begin
          if (!sts.present) begin
            ctl.latchFault = 1'b1;
            stateD         = stFault;
          end else if (sts.largeLeaf) begin
            if (sts.permOk) begin
              ctl.latchLeaf = 1'b1;
              stateD        = stDone;
            end else begin
              ctl.latchFault = 1'b1;
              stateD         = stFault;
            end
          end else begin
            ctl.latchDir = 1'b1;
            stateD       = stReadTbl;
          end
        end
      end
      stReadTbl: begin
        ctl.selTable = 1'b1;
        if (memRspValid) begin
          if (sts.present && sts.permOk) begin
            ctl.latchLeaf = 1'b1;
            stateD        = stDone;
          end else begin
            ctl.latchFault = 1'b1;
            stateD         = stFault;
          end
        end
      end
      stDone:  stateD = stIdle;
      stFault: stateD = stIdle;
      default: stateD = stIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= stIdle;
    else       stateQ <= stateD;
  end

  assign reqReady    = (stateQ == stIdle);
  assign memReqValid = (stateQ == stReadDir) || (stateQ == stReadTbl);
  assign doneValid   = (stateQ == stDone);
  assign faultValid  = (stateQ == stFault);

  // One result pulse, then back to idle
  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |=> !doneValid && !faultValid && reqReady);

  // Accepting a request starts a read and drops ready
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady && memReqValid);

endmodule

// File: rtl/va_walker.sv
module va_walker
  import va_walker_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2*IDX_W+OFF_W-1:0] baseAddr,
  input  logic        largeEn,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [2*IDX_W+OFF_W-1:0] reqVaddr,
  input  logic        reqWrite,
  input  logic        reqUser,
  output logic        memReqValid,
  output logic [2*IDX_W+OFF_W-1:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [2*IDX_W+OFF_W-1:0] memRspData,
  output logic        doneValid,
  output logic [2*IDX_W+OFF_W-1:0] donePaddr,
  output logic [2:0]  doneAttr,
  output logic        doneLarge,
  output logic        faultValid,
  output logic [2:0]  faultCode
);
  walkCtl_t ctl;
  walkSts_t sts;

  va_walker_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .sts        (sts),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .doneValid  (doneValid),
    .faultValid (faultValid)
  );

  va_walker_data #(.IDX_W(IDX_W), .OFF_W(OFF_W)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .baseAddr  (baseAddr),
    .largeEn   (largeEn),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .reqUser   (reqUser),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .sts       (sts),
    .donePaddr (donePaddr),
    .doneAttr  (doneAttr),
    .doneLarge (doneLarge),
    .faultCode (faultCode)
  );

  // A pending read holds until answered
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memReqAddr));

endmodule

// File: tb/test_va_walker.sv
`timescale 1ns/1ps
module test_va_walker;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        us;
    logic        lg;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        expFault;
    logic [2:0]  expCode;
    logic [31:0] expPaddr;
    logic [2:0]  expAttr;
    logic        expLarge;
    logic [1:0]  expReads;
    logic [1:0]  lat;
  } vec_t;

  localparam int NVEC = 13;
  localparam logic [31:0] BASE = 32'h0010_0000;

  // Code bits: [2]=user, [1]=write, [0]=protection. Attr: {global, nocache, wthru}.
  localparam vec_t VECS [NVEC] = '{
    // R3 small page read
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h0020_0003, 32'hABCD_E003, 1'b0, 3'b000, 32'hABCD_E678, 3'b000, 1'b0, 2'd2, 2'd0},
    // R11 attrs and ignored bits 11..9, user write allowed
    '{32'h0000_1ABC, 1'b1, 1'b1, 1'b0, 32'h0030_0007, 32'h5555_5F1F, 1'b0, 3'b000, 32'h5555_5ABC, 3'b111, 1'b0, 2'd2, 2'd1},
    // R4 large page with global
    '{32'h8765_4321, 1'b0, 1'b0, 1'b1, 32'hC03A_5183, 32'h0000_0000, 1'b0, 3'b000, 32'hC025_4321, 3'b100, 1'b1, 2'd1, 2'd2},
    // R5 size bit ignored when disabled
    '{32'h0040_2FFF, 1'b0, 1'b0, 1'b0, 32'h0060_0083, 32'h1111_1001, 1'b0, 3'b000, 32'h1111_1FFF, 3'b000, 1'b0, 2'd2, 2'd3},
    // R6 directory not present, user write
    '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0070_0006, 32'h0000_0000, 1'b1, 3'b110, 32'h0, 3'b000, 1'b0, 2'd1, 2'd0},
    // R6 table not present, supervisor read
    '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0070_0003, 32'h2222_2000, 1'b1, 3'b000, 32'h0, 3'b000, 1'b0, 2'd2, 2'd1},
    // R7 directory read-only, supervisor write
    '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0080_0005, 32'h3333_3003, 1'b1, 3'b011, 32'h0, 3'b000, 1'b0, 2'd2, 2'd0},
    // R7 table read-only, user write
    '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0090_0007, 32'h4444_4005, 1'b1, 3'b111, 32'h0, 3'b000, 1'b0, 2'd2, 2'd2},
    // R8 directory supervisor-only, user read
    '{32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h00A0_0003, 32'h5555_5007, 1'b1, 3'b101, 32'h0, 3'b000, 1'b0, 2'd2, 2'd1},
    // R8 supervisor read ignores user and write bits
    '{32'h0000_0123, 1'b0, 1'b0, 1'b0, 32'h00A0_0001, 32'h6666_6001, 1'b0, 3'b000, 32'h6666_6123, 3'b000, 1'b0, 2'd2, 2'd0},
    // R7 large page read-only, user write
    '{32'h0000_0000, 1'b1, 1'b1, 1'b1, 32'h0400_0085, 32'h0000_0000, 1'b1, 3'b111, 32'h0, 3'b000, 1'b0, 2'd1, 2'd3},
    // R6 large bit on non-present entry, user read
    '{32'h0000_0000, 1'b0, 1'b1, 1'b1, 32'h0000_0080, 32'h0000_0000, 1'b1, 3'b100, 32'h0, 3'b000, 1'b0, 2'd1, 2'd0},
    // R3 small page while large pages enabled
    '{32'h0040_2FFF, 1'b0, 1'b0, 1'b1, 32'h0060_0003, 32'h7777_7001, 1'b0, 3'b000, 32'h7777_7FFF, 3'b000, 1'b0, 2'd2, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baseAddr = BASE;
  logic        largeEn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [31:0] donePaddr;
  logic [2:0]  doneAttr;
  logic        doneLarge;
  logic        faultValid;
  logic [2:0]  faultCode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] curPde, curPte, curPdeAddr, curPteAddr;
  int          curLat = 0;
  int          readCnt = 0;
  bit          holdBad = 0;
  logic [31:0] rdAddr [4];

  always #2 clk = ~clk;

  va_walker i_va_walker (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .largeEn(largeEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePaddr(donePaddr), .doneAttr(doneAttr),
    .doneLarge(doneLarge), .faultValid(faultValid), .faultCode(faultCode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a == curPdeAddr) return curPde;
    if (a == curPteAddr) return curPte;
    return 32'h0;
  endfunction

  // Memory model: answers a pending read after curLat cycles
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rstN && memReqValid) begin
        logic [31:0] a;
        a = memReqAddr;
        for (int i = 0; i < curLat; i++) begin
          @(negedge clk);
          if (!memReqValid || memReqAddr !== a) holdBad = 1;
        end
        memRspData  = lookup(a);
        memRspValid = 1'b1;
        if (readCnt < 4) rdAddr[readCnt] = a;
        readCnt++;
      end
    end
  end

  task automatic startWalk(input vec_t v);
    @(negedge clk);
    curPde     = v.pde;
    curPte     = v.pte;
    curPdeAddr = {BASE[31:12], v.va[31:22], 2'b00};     // R2
    curPteAddr = {v.pde[31:12], v.va[21:12], 2'b00};    // R3
    curLat     = int'(v.lat);
    readCnt    = 0;
    holdBad    = 0;
    largeEn    = v.lg;
    reqVaddr   = v.va;
    reqWrite   = v.wr;
    reqUser    = v.us;
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid   = 1'b0;
  endtask

  task automatic finishWalk(input vec_t v, input int idx);
    int t;
    t = 0;
    while (!(doneValid || faultValid) && t < 60) begin
      @(negedge clk);
      t++;
    end
    $display("vector %0d", idx);
    chk("R10 result seen", {31'b0, doneValid || faultValid}, 32'd1);
    chk("R6 fault vs done", {30'b0, faultValid, doneValid}, {30'b0, v.expFault, !v.expFault});
    if (v.expFault) begin
      chk("R6 R7 R8 fault code", {29'b0, faultCode}, {29'b0, v.expCode});
    end else begin
      chk("R3 R4 paddr", donePaddr, v.expPaddr);
      chk("R11 attr", {29'b0, doneAttr}, {29'b0, v.expAttr});
      chk("R4 large flag", {31'b0, doneLarge}, {31'b0, v.expLarge});
    end
    chk("R4 R5 read count", readCnt, {30'b0, v.expReads});
    chk("R2 dir address", rdAddr[0], curPdeAddr);
    if (v.expReads == 2'd2) chk("R3 table address", rdAddr[1], curPteAddr);
    chk("R9 request hold", {31'b0, holdBad}, 32'd0);
    @(negedge clk);
    chk("R10 single pulse", {30'b0, doneValid, faultValid}, 32'd0);
    chk("R10 ready again", {31'b0, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, reqReady}, 32'd1);
    chk("R1 outputs idle", {29'b0, memReqValid, doneValid, faultValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {28'b0, reqReady, memReqValid, doneValid, faultValid}, 32'h8);

    for (int k = 0; k < NVEC; k++) begin
      startWalk(VECS[k]);
      finishWalk(VECS[k], k);
    end

    // R10: requests during a walk are ignored
    begin
      vec_t v;
      v = VECS[0];
      v.lat = 2'd3;
      startWalk(v);
      chk("R10 busy not ready", {31'b0, reqReady}, 32'd0);
      reqVaddr = 32'hFFFF_F000;
      reqWrite = 1'b1;
      reqUser  = 1'b1;
      reqValid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      finishWalk(v, 99);
      repeat (5) begin
        @(negedge clk);
        chk("R10 no extra activity", {29'b0, memReqValid, doneValid, faultValid}, 32'd0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule